// File: doc/BRIEF.md
# Interrupt Acknowledge and Halt Controller

This block makes the interrupt and halt decisions for a small microcoded 8-bit processor. It has an enable bit that software sets and clears, and a pending bit that records a request seen on the interrupt line. At every instruction boundary, which the sequencer marks with its end strobe, the block tells the sequencer where execution goes next. The choices are a plain opcode fetch, an acknowledge fetch, or the halt loop. The block also supplies the microcode entry address for that choice.

When an interrupt is taken, the acknowledge output rises. It stays high for the whole of the vector instruction that the normal datapath fetches and runs. While it is high, the block blocks the automatic program-counter increment but passes explicit program-counter loads through unchanged, so any opcode can serve as a vector. The halted output is set when the halt loop is entered. It is cleared only by reset or by leaving the loop to service an interrupt.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `intack_ctrl`

## Requirements
- R1: Reset clears the enable, pending, acknowledge and halted outputs to 0.
- R2: A set strobe makes `int_en` 1 on the next cycle and a clear strobe makes it 0. When both strobes arrive in the same cycle, the clear wins.
- R3: `irq_in` sampled high on a rising edge sets `irq_pend` only if `int_en` was already 1 before that edge. Once set, `irq_pend` stays set until it is taken.
- R4: The encoding of `entry_sel` is 0 = continue in sequence, 1 = normal fetch, 2 = acknowledge fetch, 3 = halt loop. When `end_stb` is high and `irq_pend` is 1, `entry_sel` is 2 and `entry_addr` is FETCH_ADDR in the same cycle. On the next cycle `inta` is 1 and both `irq_pend` and `int_en` are 0.
- R5: When `end_stb` is high, `irq_pend` is 0 and `halt_stb` is low, `entry_sel` is 1 and `entry_addr` is FETCH_ADDR.
- R6: `inta` stays 1 through every cycle of the vector instruction. After the next boundary that takes no interrupt, `inta` returns to 0 and `int_en` stays 0.
- R7: `pc_inc_en` follows `pc_inc_req` except while `inta` is 1, when it is 0. `pc_load_en` follows `pc_load_req` at all times.
- R8: When `end_stb` and `halt_stb` are both high and `irq_pend` is 0, `entry_sel` is 3 and `entry_addr` is HALT_ADDR. `halted` becomes 1 on the next cycle and stays 1 while the loop repeats.
- R9: When `end_stb` and `halt_stb` are both high and `irq_pend` is 1, the acknowledge choice (2) wins. On the next cycle `halted` is 0 and `inta` is 1.
- R10: While `end_stb` is low, `entry_sel` is 0, `entry_addr` is 0, and `halted` and `inta` keep their values.
- R11: A set-enable strobe in the same cycle that an interrupt is taken has no effect, and `int_en` reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 1 | Interrupt request level |
| ei_stb | input | 1 | Set the interrupt enable |
| di_stb | input | 1 | Clear the interrupt enable |
| halt_stb | input | 1 | Halt request from the current micro-step |
| end_stb | input | 1 | Current instruction ends this cycle |
| pc_inc_req | input | 1 | Sequencer asks for a PC increment |
| pc_load_req | input | 1 | Sequencer asks for an explicit PC load |
| inta | output | 1 | Interrupt acknowledge, high for the vector instruction |
| halted | output | 1 | Processor is in the halt loop |
| int_en | output | 1 | Interrupt enable state |
| irq_pend | output | 1 | Interrupt pending state |
| entry_sel | output | 2 | Next-entry choice: 0 sequence, 1 fetch, 2 acknowledge, 3 halt |
| entry_addr | output | ADDR_W | Microcode entry address for the choice, 0 when in sequence |
| pc_inc_en | output | 1 | Gated PC increment enable |
| pc_load_en | output | 1 | Explicit PC load enable |

## Verification
The properties assume that the sequencer raises `ei_stb`, `di_stb` and `halt_stb` only as single-cycle strobes. They also assume that `end_stb` marks exactly one cycle per instruction. They do not assume that `irq_in` is synchronous to any instruction. The stimulus drives every input on the falling edge and holds it for one full cycle. Boundaries are kept at least one cycle apart, except in the halt loop, where the sequencer really does issue back-to-back boundaries.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [1:0] {
    SEL_SEQ   = 2'd0,
    SEL_FETCH = 2'd1,
    SEL_ACK   = 2'd2,
    SEL_HALT  = 2'd3
  } entry_sel_t;
endpackage

// File: rtl/intack_enable_pend.sv
module intack_enable_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_in,
  input  logic set_en,
  input  logic clr_en,
  input  logic take,
  output logic int_en,
  output logic pending
);
  // Enable bit: taking an interrupt or a clear strobe beats a set strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_en <= 1'b0;
    end else if (take || clr_en) begin
      int_en <= 1'b0;
    end else if (set_en) begin
      int_en <= 1'b1;
    end
  end

  // Pending bit: only latched while enabled; taking it clears it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (take) begin
      pending <= 1'b0;
    end else if (irq_in && int_en) begin
      pending <= 1'b1;
    end
  end
endmodule

// File: rtl/intack_boundary.sv
module intack_boundary
  import intack_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int FETCH_ADDR = 3,
  parameter int HALT_ADDR  = 7
) (
  input  logic              end_stb,
  input  logic              halt_stb,
  input  logic              pending,
  output entry_sel_t        sel,
  output logic [ADDR_W-1:0] addr,
  output logic              take,
  output logic              to_halt
);
  localparam logic [ADDR_W-1:0] FETCH_A = ADDR_W'(FETCH_ADDR);
  localparam logic [ADDR_W-1:0] HALT_A  = ADDR_W'(HALT_ADDR);

  always_comb begin
    sel     = SEL_SEQ;
    addr    = '0;
    take    = 1'b0;
    to_halt = 1'b0;
    if (end_stb) begin
      if (pending) begin
        sel  = SEL_ACK;
        addr = FETCH_A;
        take = 1'b1;
      end else if (halt_stb) begin
        sel     = SEL_HALT;
        addr    = HALT_A;
        to_halt = 1'b1;
      end else begin
        sel  = SEL_FETCH;
        addr = FETCH_A;
      end
    end
  end
endmodule

// File: rtl/intack_mode.sv
module intack_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic end_stb,
  input  logic take,
  input  logic to_halt,
  output logic ack,
  output logic halted
);
  // Both flags change only at instruction boundaries.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack    <= 1'b0;
      halted <= 1'b0;
    end else if (end_stb) begin
      ack    <= take;
      halted <= to_halt;
    end
  end
endmodule

// File: rtl/intack_ctrl.sv
module intack_ctrl
  import intack_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int FETCH_ADDR = 3,
  parameter int HALT_ADDR  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic              ei_stb,
  input  logic              di_stb,
  input  logic              halt_stb,
  input  logic              end_stb,
  input  logic              pc_inc_req,
  input  logic              pc_load_req,
  output logic              inta,
  output logic              halted,
  output logic              int_en,
  output logic              irq_pend,
  output logic [1:0]        entry_sel,
  output logic [ADDR_W-1:0] entry_addr,
  output logic              pc_inc_en,
  output logic              pc_load_en
);
  entry_sel_t sel_w;
  logic       take_w;
  logic       to_halt_w;

  intack_enable_pend u_enpend (
    .clk     (clk),
    .rst_n   (rst_n),
    .irq_in  (irq_in),
    .set_en  (ei_stb),
    .clr_en  (di_stb),
    .take    (take_w),
    .int_en  (int_en),
    .pending (irq_pend)
  );

  intack_boundary #(
    .ADDR_W     (ADDR_W),
    .FETCH_ADDR (FETCH_ADDR),
    .HALT_ADDR  (HALT_ADDR)
  ) u_bound (
    .end_stb  (end_stb),
    .halt_stb (halt_stb),
    .pending  (irq_pend),
    .sel      (sel_w),
    .addr     (entry_addr),
    .take     (take_w),
    .to_halt  (to_halt_w)
  );

  intack_mode u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .end_stb (end_stb),
    .take    (take_w),
    .to_halt (to_halt_w),
    .ack     (inta),
    .halted  (halted)
  );

  assign entry_sel  = sel_w;
  // The vector instruction keeps the PC where the vector left it, unless it
  // writes the PC explicitly.
  assign pc_inc_en  = pc_inc_req & ~inta;
  assign pc_load_en = pc_load_req;
endmodule

// File: rtl/intack_ctrl_chk.sv
module intack_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_in,
  input logic       ei_stb,
  input logic       di_stb,
  input logic       halt_stb,
  input logic       end_stb,
  input logic       pc_inc_req,
  input logic       inta,
  input logic       halted,
  input logic       int_en,
  input logic       irq_pend,
  input logic [1:0] entry_sel,
  input logic       pc_inc_en
);
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    di_stb |=> !int_en);

  a_r3_no_latch_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!int_en && !irq_pend) |=> !irq_pend);

  a_r3_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !end_stb) |=> irq_pend);

  a_r4_take: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && irq_pend) |=> (inta && !irq_pend && !int_en));

  a_r6_ack_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && !end_stb) |=> inta);

  a_r6_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && end_stb && !irq_pend) |=> !inta);

  a_r7_no_inc_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (inta && pc_inc_req) |-> !pc_inc_en);

  a_r8_enter_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && halt_stb && !irq_pend) |=> halted);

  a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && end_stb && irq_pend) |=> (!halted && inta));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !end_stb |=> ($stable(halted) && $stable(inta)));

  a_r10_seq_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !end_stb |-> (entry_sel == 2'd0));

  a_r11_no_enable_on_take: assert property (@(posedge clk) disable iff (!rst_n)
    (end_stb && irq_pend && ei_stb) |=> !int_en);

  a_r1_not_both: assert property (@(posedge clk) disable iff (!rst_n)
    !(inta && halted));
endmodule

bind intack_ctrl intack_ctrl_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .irq_in     (irq_in),
  .ei_stb     (ei_stb),
  .di_stb     (di_stb),
  .halt_stb   (halt_stb),
  .end_stb    (end_stb),
  .pc_inc_req (pc_inc_req),
  .inta       (inta),
  .halted     (halted),
  .int_en     (int_en),
  .irq_pend   (irq_pend),
  .entry_sel  (entry_sel),
  .pc_inc_en  (pc_inc_en)
);

// File: tb/test_intack_ctrl.sv
module test_intack_ctrl;
  localparam int AW = 9;
  localparam int FA = 3;
  localparam int HA = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_in = 1'b0, ei_stb = 1'b0, di_stb = 1'b0, halt_stb = 1'b0, end_stb = 1'b0;
  logic pc_inc_req = 1'b0, pc_load_req = 1'b0;
  logic inta, halted, int_en, irq_pend, pc_inc_en, pc_load_en;
  logic [1:0] entry_sel;
  logic [AW-1:0] entry_addr;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  intack_ctrl #(.ADDR_W(AW), .FETCH_ADDR(FA), .HALT_ADDR(HA)) i_intack_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ei_stb(ei_stb), .di_stb(di_stb),
    .halt_stb(halt_stb), .end_stb(end_stb), .pc_inc_req(pc_inc_req),
    .pc_load_req(pc_load_req), .inta(inta), .halted(halted), .int_en(int_en),
    .irq_pend(irq_pend), .entry_sel(entry_sel), .entry_addr(entry_addr),
    .pc_inc_en(pc_inc_en), .pc_load_en(pc_load_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle();
    irq_in = 0; ei_stb = 0; di_stb = 0; halt_stb = 0; end_stb = 0;
    pc_inc_req = 0; pc_load_req = 0;
  endtask

  // Inputs settle on the falling edge; the next rising edge captures them.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic settle();
    #0.5;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    step();
    rst_n = 1;
    step();
  endtask

  task automatic t_reset();
    chk("R1 inta", int'(inta), 0);
    chk("R1 halted", int'(halted), 0);
    chk("R1 int_en", int'(int_en), 0);
    chk("R1 irq_pend", int'(irq_pend), 0);
    end_stb = 1; settle();
    chk("R5 sel fetch", int'(entry_sel), 1);
    chk("R5 addr fetch", int'(entry_addr), FA);
    step(); idle();
    chk("R5 no ack", int'(inta), 0);
  endtask

  task automatic t_ei_di();
    ei_stb = 1; step(); idle();
    chk("R2 set", int'(int_en), 1);
    ei_stb = 1; di_stb = 1; step(); idle();
    chk("R2 clear wins", int'(int_en), 0);
    ei_stb = 1; step(); idle();
    di_stb = 1; step(); idle();
    chk("R2 clear", int'(int_en), 0);
  endtask

  task automatic t_pend_gate();
    irq_in = 1; step(); step();
    chk("R3 disabled ignores", int'(irq_pend), 0);
    ei_stb = 1; step(); ei_stb = 0;
    chk("R3 old enable used", int'(irq_pend), 0);
    step(); idle();
    chk("R3 latched", int'(irq_pend), 1);
    step(); step();
    chk("R3 held", int'(irq_pend), 1);
  endtask

  task automatic t_accept_vector();
    pc_inc_req = 1; settle();
    chk("R7 inc before ack", int'(pc_inc_en), 1);
    end_stb = 1; settle();
    chk("R4 sel ack", int'(entry_sel), 2);
    chk("R4 addr", int'(entry_addr), FA);
    step(); idle();
    chk("R4 inta", int'(inta), 1);
    chk("R4 pend cleared", int'(irq_pend), 0);
    chk("R4 enable cleared", int'(int_en), 0);
    pc_inc_req = 1; pc_load_req = 1; settle();
    chk("R7 inc blocked", int'(pc_inc_en), 0);
    chk("R7 load passes", int'(pc_load_en), 1);
    chk("R10 sel seq", int'(entry_sel), 0);
    chk("R10 addr zero", int'(entry_addr), 0);
    step(); step(); step(); idle();
    chk("R6 held", int'(inta), 1);
    end_stb = 1; settle();
    chk("R6 fetch after vector", int'(entry_sel), 1);
    step(); idle();
    chk("R6 dropped", int'(inta), 0);
    chk("R6 still disabled", int'(int_en), 0);
    pc_inc_req = 1; settle();
    chk("R7 inc restored", int'(pc_inc_en), 1);
    idle();
  endtask

  task automatic t_halt();
    halt_stb = 1; end_stb = 1; settle();
    chk("R8 sel halt", int'(entry_sel), 3);
    chk("R8 addr halt", int'(entry_addr), HA);
    step();
    chk("R8 halted", int'(halted), 1);
    step(); step(); settle();
    chk("R8 loop stays", int'(halted), 1);
    chk("R8 loop sel", int'(entry_sel), 3);
    idle(); halt_stb = 1; step(); idle();
    chk("R10 halt alone", int'(halted), 1);
    step();
    chk("R10 halted stable", int'(halted), 1);
  endtask

  task automatic t_halt_wake();
    ei_stb = 1; halt_stb = 1; end_stb = 1; step();
    ei_stb = 0; irq_in = 1; step(); irq_in = 0; settle();
    chk("R3 pend while halted", int'(irq_pend), 1);
    chk("R9 sel ack", int'(entry_sel), 2);
    step(); idle();
    chk("R9 unhalted", int'(halted), 0);
    chk("R9 inta", int'(inta), 1);
    end_stb = 1; step(); idle();
    chk("R6 vector done", int'(inta), 0);
  endtask

  task automatic t_ei_on_take();
    ei_stb = 1; step();
    ei_stb = 0; irq_in = 1; step(); irq_in = 0;
    end_stb = 1; ei_stb = 1; step(); idle();
    chk("R11 enable stays off", int'(int_en), 0);
    chk("R11 inta", int'(inta), 1);
    end_stb = 1; step(); idle();
  endtask

  task automatic t_reset_mid();
    halt_stb = 1; end_stb = 1; step(); idle();
    ei_stb = 1; step(); idle();
    irq_in = 1; step(); idle();
    rst_n = 0; #0.5;
    chk("R1 async halted", int'(halted), 0);
    chk("R1 async pend", int'(irq_pend), 0);
    chk("R1 async enable", int'(int_en), 0);
    step(); rst_n = 1; step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    do_reset();
    t_reset();
    t_ei_di();
    t_pend_gate();
    t_accept_vector();
    t_halt();
    do_reset();
    t_halt_wake();
    t_ei_on_take();
    t_reset_mid();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule